// File: doc/BRIEF.md
# General-Purpose Register Bank with Part-Select Access

This block holds eight 32-bit general-purpose registers behind one write port and two independent read ports. Every port carries a register index and a two-bit part selector. The selector chooses the whole register, its low half, its low byte, or the byte just above the low byte. Narrow writes merge into the stored word and leave all other bits as they were. Narrow reads return the selected part, zero-extended, in the least significant bits of a 32-bit result.

Only the first four registers (indices 0 to 3) expose the upper byte of their low half. The other four support only full and low-half access. When a port asks for that upper byte on one of those four registers, the request is flagged. A flagged write is dropped, and a flagged read returns zero.

Reads are combinational from the stored state. A write takes effect at the rising clock edge. A reset asserted at a clock edge clears every register.

Top module: `gpr_bank`

## Requirements
- R1: The bank holds eight independent 32-bit registers, indexed 0 to 7. A full-width write (part 00) to one index changes only that register, and a full-width read of it returns the written word.
- R2: The part selector encodes 00 = bits 31:0, 01 = bits 15:0, 10 = bits 7:0, 11 = bits 15:8. A read with part 11 on index 0 to 3 returns bits 15:8 of the register in result bits 7:0.
- R3: A write with part 01 replaces bits 15:0 and leaves bits 31:16 of the register unchanged.
- R4: A write with part 10 replaces only bits 7:0, and a write with part 11 on index 0 to 3 replaces only bits 15:8. All other bits keep their values.
- R5: A write with part 11 to index 4 to 7 raises `wr_bad` in the same cycle and leaves the register unchanged. `wr_bad` is low for every other write and whenever `wr_en` is low.
- R6: Read results are zero-extended: with part 01 bits 31:16 are zero, and with part 10 or 11 bits 31:8 are zero. A read with part 11 on index 4 to 7 returns zero and raises that port's `*_bad` flag.
- R7: A read of a register during the cycle in which it is written returns the value from before the write. The new value is visible from the cycle after the clock edge.
- R8: While `rst` is high at a rising clock edge, all registers become zero, and any write in that cycle is discarded.
- R9: The two read ports are independent: each may address any register with any part in the same cycle, including the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_idx | input | 3 | Destination register index |
| wr_part | input | 2 | Destination part selector |
| wr_data | input | 32 | Write data, selected part taken from the low bits |
| wr_bad | output | 1 | Write request targets an unavailable part |
| ra_idx | input | 3 | Read port A register index |
| ra_part | input | 2 | Read port A part selector |
| ra_data | output | 32 | Read port A result, zero-extended |
| ra_bad | output | 1 | Read port A addresses an unavailable part |
| rb_idx | input | 3 | Read port B register index |
| rb_part | input | 2 | Read port B part selector |
| rb_data | output | 32 | Read port B result, zero-extended |
| rb_bad | output | 1 | Read port B addresses an unavailable part |

## Verification
The merge properties assume that read port A looks at the same register, at full width, in the cycle of a write and in the cycle after it. Otherwise they hold vacuously. The stimulus often sets up that pairing on purpose, and the random phase reaches it often, so the properties see real traffic.

The properties also assume that `rst` is high from time zero. They take all port inputs as known values at each edge. The bench drives every input on the falling edge, starts in reset, and never leaves an input undriven.

// File: rtl/gpr_bank.sv
module gpr_bank #(
  parameter int NREG  = 8,
  parameter int XLEN  = 32,
  parameter int NWIDE = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [$clog2(NREG)-1:0] wr_idx,
  input  logic [1:0]              wr_part,
  input  logic [XLEN-1:0]         wr_data,
  output logic                    wr_bad,
  input  logic [$clog2(NREG)-1:0] ra_idx,
  input  logic [1:0]              ra_part,
  output logic [XLEN-1:0]         ra_data,
  output logic                    ra_bad,
  input  logic [$clog2(NREG)-1:0] rb_idx,
  input  logic [1:0]              rb_part,
  output logic [XLEN-1:0]         rb_data,
  output logic                    rb_bad
);
  localparam int IDXW = $clog2(NREG);
  localparam logic [1:0] P_FULL = 2'b00;
  localparam logic [1:0] P_HALF = 2'b01;
  localparam logic [1:0] P_LOB  = 2'b10;
  localparam logic [1:0] P_HIB  = 2'b11;

  logic [XLEN-1:0] regs [NREG];
  logic [XLEN-1:0] merged;

  function automatic logic no_hib(input logic [IDXW-1:0] idx, input logic [1:0] part);
    return (idx >= IDXW'(NWIDE)) && (part == P_HIB);
  endfunction

  function automatic logic [XLEN-1:0] pick(input logic [XLEN-1:0] v, input logic [1:0] part);
    case (part)
      P_FULL:  return v;
      P_HALF:  return {{(XLEN-16){1'b0}}, v[15:0]};
      P_LOB:   return {{(XLEN-8){1'b0}}, v[7:0]};
      default: return {{(XLEN-8){1'b0}}, v[15:8]};
    endcase
  endfunction

  assign wr_bad = wr_en & no_hib(wr_idx, wr_part);
  assign ra_bad = no_hib(ra_idx, ra_part);
  assign rb_bad = no_hib(rb_idx, rb_part);
  assign ra_data = ra_bad ? '0 : pick(regs[ra_idx], ra_part);
  assign rb_data = rb_bad ? '0 : pick(regs[rb_idx], rb_part);

  always_comb begin
    merged = regs[wr_idx];
    case (wr_part)
      P_FULL:  merged = wr_data;
      P_HALF:  merged[15:0] = wr_data[15:0];
      P_LOB:   merged[7:0] = wr_data[7:0];
      default: merged[15:8] = wr_data[7:0];
    endcase
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[i] <= '0;
      else if (wr_en && !wr_bad && wr_idx == IDXW'(i))
        regs[i] <= merged;
    end
  end
endmodule

// File: rtl/gpr_bank_chk.sv
module gpr_bank_chk #(
  parameter int NREG = 8,
  parameter int XLEN = 32
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    wr_en,
  input logic [$clog2(NREG)-1:0] wr_idx,
  input logic [1:0]              wr_part,
  input logic [XLEN-1:0]         wr_data,
  input logic                    wr_bad,
  input logic [$clog2(NREG)-1:0] ra_idx,
  input logic [1:0]              ra_part,
  input logic [XLEN-1:0]         ra_data,
  input logic                    ra_bad,
  input logic [XLEN-1:0]         rb_data
);
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ra_data == '0 && rb_data == '0)); // R8

  AST_FULL_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en && wr_part == 2'b00) && ra_idx == $past(wr_idx) && ra_part == 2'b00)
    |-> ra_data == $past(wr_data)); // R1

  AST_HALF_MERGE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en && wr_part == 2'b01 && ra_idx == wr_idx && ra_part == 2'b00)
     && ra_idx == $past(wr_idx) && ra_part == 2'b00)
    |-> ra_data == {$past(ra_data[31:16]), $past(wr_data[15:0])}); // R3

  AST_BYTE_MERGE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en && wr_part == 2'b10 && ra_idx == wr_idx && ra_part == 2'b00)
     && ra_idx == $past(wr_idx) && ra_part == 2'b00)
    |-> ra_data == {$past(ra_data[31:8]), $past(wr_data[7:0])}); // R4

  AST_DROPPED_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_bad && ra_idx == wr_idx && ra_part == 2'b00)
     && ra_idx == $past(ra_idx) && ra_part == 2'b00)
    |-> ra_data == $past(ra_data)); // R5

  AST_NO_IDLE_FLAG: assert property (@(posedge clk) disable iff (rst)
    !wr_en |-> !wr_bad); // R5

  AST_HALF_ZEXT: assert property (@(posedge clk) disable iff (rst)
    ra_part == 2'b01 |-> ra_data[31:16] == '0); // R6

  AST_BYTE_ZEXT: assert property (@(posedge clk) disable iff (rst)
    ra_part[1] |-> ra_data[31:8] == '0); // R6

  AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    ra_bad |-> ra_data == '0); // R6
endmodule

bind gpr_bank gpr_bank_chk #(.NREG(NREG), .XLEN(XLEN)) i_gpr_bank_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_part(wr_part),
  .wr_data(wr_data), .wr_bad(wr_bad), .ra_idx(ra_idx), .ra_part(ra_part),
  .ra_data(ra_data), .ra_bad(ra_bad), .rb_data(rb_data)
);

// File: tb/test_gpr_bank.sv
`timescale 1ns/1ps
module test_gpr_bank;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [2:0] wr_idx = '0;
  logic [1:0] wr_part = '0;
  logic [31:0] wr_data = '0;
  logic wr_bad;
  logic [2:0] ra_idx = '0, rb_idx = '0;
  logic [1:0] ra_part = '0, rb_part = '0;
  logic [31:0] ra_data, rb_data;
  logic ra_bad, rb_bad;

  always #5 clk = ~clk;

  gpr_bank i_gpr_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_part(wr_part),
    .wr_data(wr_data), .wr_bad(wr_bad), .ra_idx(ra_idx), .ra_part(ra_part),
    .ra_data(ra_data), .ra_bad(ra_bad), .rb_idx(rb_idx), .rb_part(rb_part),
    .rb_data(rb_data), .rb_bad(rb_bad)
  );

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] b;
    logic        abad;
    logic        bbad;
    logic        wbad;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  logic [31:0] mdl [8];
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  function automatic bit illegal(input logic [2:0] idx, input logic [1:0] part);
    return idx >= 3'd4 && part == 2'b11;
  endfunction

  function automatic logic [31:0] rd_mdl(input logic [2:0] idx, input logic [1:0] part);
    logic [31:0] v = mdl[idx];
    if (illegal(idx, part)) return 32'h0;
    case (part)
      2'b00: return v;
      2'b01: return {16'h0, v[15:0]};
      2'b10: return {24'h0, v[7:0]};
      default: return {24'h0, v[15:8]};
    endcase
  endfunction

  task automatic step(input bit we, input logic [2:0] wi, input logic [1:0] wp,
                      input logic [31:0] wd, input logic [2:0] ai, input logic [1:0] ap,
                      input logic [2:0] bi, input logic [1:0] bp, input string tag);
    exp_t e;
    @(negedge clk);
    wr_en = we; wr_idx = wi; wr_part = wp; wr_data = wd;
    ra_idx = ai; ra_part = ap; rb_idx = bi; rb_part = bp;
    e.a = rd_mdl(ai, ap);
    e.b = rd_mdl(bi, bp);
    e.abad = illegal(ai, ap);
    e.bbad = illegal(bi, bp);
    e.wbad = we && illegal(wi, wp);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    if (we && !illegal(wi, wp)) begin
      case (wp)
        2'b00: mdl[wi] = wd;
        2'b01: mdl[wi][15:0] = wd[15:0];
        2'b10: mdl[wi][7:0] = wd[7:0];
        default: mdl[wi][15:8] = wd[7:0];
      endcase
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b1; wr_idx = 3'd2; wr_part = 2'b00; wr_data = 32'hFFFF_FFFF;
    @(negedge clk);
    rst = 1'b0; wr_en = 1'b0;
    for (int k = 0; k < 8; k++) mdl[k] = 32'h0;
  endtask

  initial begin : monitor
    exp_t e;
    string t;
    forever begin
      @(negedge clk);
      #2;
      if (exp_q.size() != 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if (ra_data !== e.a || rb_data !== e.b || ra_bad !== e.abad ||
            rb_bad !== e.bbad || wr_bad !== e.wbad) begin
          n_fail++;
          $display("FAIL %s: got a=%h b=%h abad=%b bbad=%b wbad=%b, expected a=%h b=%h abad=%b bbad=%b wbad=%b",
                   t, ra_data, rb_data, ra_bad, rb_bad, wr_bad,
                   e.a, e.b, e.abad, e.bbad, e.wbad);
        end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 10);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got no end, expected end of stimulus");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : driver
    for (int k = 0; k < 8; k++) mdl[k] = 32'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 8; k++) step(0, 0, 0, 0, 3'(k), 2'b00, 3'(7 - k), 2'b00, "R8 after reset");
    for (int k = 0; k < 8; k++) step(1, 3'(k), 2'b00, 32'h1111_1111 * (k + 1) ^ 32'hA5C3_0F96, 3'(k), 2'b00, 3'(k), 2'b01, "R7 old value on write");
    for (int k = 0; k < 8; k++) step(0, 0, 0, 0, 3'(k), 2'b00, 3'((k + 3) % 8), 2'b00, "R1 R9 full readback");
    step(1, 3'd1, 2'b01, 32'hDEAD_BEEF, 3'd1, 2'b00, 3'd1, 2'b01, "R3 half write");
    step(0, 0, 0, 0, 3'd1, 2'b00, 3'd1, 2'b01, "R3 upper kept");
    step(1, 3'd2, 2'b10, 32'h0000_0077, 3'd2, 2'b00, 3'd2, 2'b10, "R4 low byte write");
    step(0, 0, 0, 0, 3'd2, 2'b00, 3'd2, 2'b11, "R4 low byte merged");
    step(1, 3'd3, 2'b11, 32'hFFFF_FF5A, 3'd3, 2'b00, 3'd3, 2'b11, "R4 high byte write");
    step(0, 0, 0, 0, 3'd3, 2'b00, 3'd3, 2'b11, "R2 R4 high byte merged");
    step(0, 0, 0, 0, 3'd0, 2'b11, 3'd0, 2'b10, "R2 byte extraction");
    step(1, 3'd5, 2'b11, 32'h0000_00EE, 3'd5, 2'b00, 3'd5, 2'b11, "R5 illegal write flagged");
    step(0, 0, 0, 0, 3'd5, 2'b00, 3'd6, 2'b11, "R5 R6 register kept, bad read");
    step(1, 3'd4, 2'b01, 32'h1234_5678, 3'd4, 2'b01, 3'd7, 2'b01, "R6 half zero-extend");
    step(0, 0, 0, 0, 3'd4, 2'b00, 3'd4, 2'b10, "R6 byte zero-extend");
    step(1, 3'd0, 2'b00, 32'hCAFE_F00D, 3'd0, 2'b00, 3'd0, 2'b11, "R7 same-cycle read old");
    step(0, 0, 0, 0, 3'd0, 2'b00, 3'd0, 2'b11, "R7 new value next cycle");
    for (int n = 0; n < 400; n++) begin
      logic [2:0] wi = 3'($urandom_range(0, 7));
      step(1'($urandom_range(0, 1)), wi, 2'($urandom_range(0, 3)), $urandom(),
           (n % 2 == 0) ? wi : 3'($urandom_range(0, 7)), (n % 2 == 0) ? 2'b00 : 2'($urandom_range(0, 3)),
           3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), "R4 random merge");
    end
    do_reset();
    for (int k = 0; k < 8; k++) step(0, 0, 0, 0, 3'(k), 2'b00, 3'(k), 2'b01, "R8 reset mid-run");
    @(negedge clk);
    wr_en = 1'b0;
    repeat (3) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule